// File: doc/BRIEF.md
# Link Phit/Flit Gearbox

This block sits between a narrow, fast serial link and the wider core of a switch. On the transmit side it takes one 70-bit flit at a time, made of 64 payload bits and 6 control bits, and drives it onto the link as five consecutive 14-bit phits. The lowest bits go first, and a start-of-flit marker accompanies the first phit. Because five phits form one flit, the core side only needs to offer a new flit once every five link cycles. A ready signal paces the core to that rate.

On the receive side a modulo-5 phase counter collects incoming phits. A start-of-flit marker realigns the counter to the start of a flit. The completed flit is handed to the core as a single-cycle strobe. The receiver also follows packet framing on top of the flit stream. A request packet is either a single flit or eight flits, and its first flit carries the length. The receiver flags the last flit of every packet and reports framing violations.

Top module: `link_phit_gearbox`

## Requirements
- R1: After reset, txReady is 1, and txPhitValid, rxFlitValid, rxPktEnd, rxFrameErr and rxAlignErr are 0.
- R2: A flit accepted at a clock edge appears on txPhit over the next five cycles, bits [13:0] first, then [27:14], [41:28], [55:42] and [69:56]. txPhitValid is high in all five cycles and txSof is high only in the first.
- R3: txReady is high only when no phit is being sent or the current phit is the last one of its flit. A flit offered while txReady is low is not taken and does not change the phits on the link.
- R4: Flits offered back to back leave the link with no idle cycle: successive txSof pulses are exactly five cycles apart.
- R5: A phit marked with rxSof, followed by four more valid phits, produces a one-cycle rxFlitValid pulse in the cycle after the fifth phit. rxFlit holds the phits reassembled with the first phit in bits [13:0].
- R6: Cycles with rxPhitValid low pause reception without losing the phase inside a flit.
- R7: An rxSof phit that arrives while a flit is partly gathered discards the partial flit and starts a new one.
- R8: A valid phit without rxSof, arriving when no flit is in progress, is dropped. It raises rxAlignErr for one cycle, produces no flit and does not disturb the packet framing.
- R9: Flit bit 64 marks the first flit of a packet and bit 65 gives its length (0 = one flit, 1 = eight flits). rxPktEnd is raised together with rxFlitValid on the last flit of each packet.
- R10: rxFrameErr is raised with a flit that either starts a packet while the previous packet still owes flits, or continues a packet when none is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link phit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txFlitValid | input | 1 | Core offers a flit to send |
| txFlit | input | 70 | Flit to send (64 data, 6 control) |
| txReady | output | 1 | Flit taken at this edge when txFlitValid is high |
| txPhitValid | output | 1 | txPhit carries a phit |
| txPhit | output | 14 | Outgoing phit |
| txSof | output | 1 | First phit of a flit |
| rxPhitValid | input | 1 | rxPhit carries a phit |
| rxPhit | input | 14 | Incoming phit |
| rxSof | input | 1 | Incoming phit starts a flit |
| rxFlitValid | output | 1 | One-cycle strobe: rxFlit is complete |
| rxFlit | output | 70 | Reassembled flit |
| rxPktEnd | output | 1 | Delivered flit closes its packet |
| rxFrameErr | output | 1 | Delivered flit breaks packet framing |
| rxAlignErr | output | 1 | Stray phit outside a flit was dropped |

## Verification
The bench builds the block with its default parameters: 14-bit phits, five phits per flit, 64 data and 6 control bits, and long packets of eight flits. With these values every phase of both counters is reached, and so is the full countdown of a long packet. Most traffic runs through an external loopback from transmitter to receiver. For the receive-only cases, such as gaps, realignment and stray phits, the bench drives the receive pins directly.

// File: rtl/link_gearbox_pkg.sv
package link_gearbox_pkg;

  // Strobes from the control unit to the datapath, one per cycle.
  typedef struct packed {
    logic txLoad;     // capture a new flit into the transmit shifter
    logic txShift;    // advance the transmit shifter by one phit
    logic rxShift;    // push the incoming phit into the gather register
    logic rxDeliver;  // incoming phit completes a flit
    logic pktEnd;     // delivered flit closes its packet
    logic pktErr;     // delivered flit violates framing
    logic alignErr;   // incoming phit dropped, no flit in progress
  } gear_strobe_t;

endpackage

// File: rtl/link_gearbox_ctrl.sv
module link_gearbox_ctrl
  import link_gearbox_pkg::*;
#(
  parameter int PHITS      = 5,
  parameter int LONG_FLITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txFlitValid,
  output logic         txReady,
  output logic         txPhitValid,
  output logic         txSof,
  input  logic         rxPhitValid,
  input  logic         rxSof,
  input  logic         rxHeadBit,
  input  logic         rxLenBit,
  output gear_strobe_t strobe
);

  localparam int CNT_W = $clog2(PHITS + 1);
  localparam int PH_W  = $clog2(PHITS);
  localparam int REM_W = $clog2(LONG_FLITS);

  logic [CNT_W-1:0] txLeft;     // phits of the current flit still on the wire
  logic [PH_W-1:0]  rxPhase;    // phits gathered of the current flit
  logic [REM_W-1:0] pktRemain;  // flits still owed by the open packet
  logic [REM_W-1:0] pktRemainNext;

  // Transmit pacing
  assign txReady     = (txLeft <= CNT_W'(1));
  assign txPhitValid = (txLeft != '0);
  assign txSof       = (txLeft == CNT_W'(PHITS));

  always_ff @(posedge clk) begin
    if (!rst_n)            txLeft <= '0;
    else if (strobe.txLoad) txLeft <= CNT_W'(PHITS);
    else if (txLeft != '0)  txLeft <= txLeft - CNT_W'(1);
  end

  // Receive phase and packet framing
  always_comb begin
    strobe           = '0;
    strobe.txLoad    = txFlitValid && txReady;
    strobe.txShift   = !strobe.txLoad && (txLeft != '0);
    strobe.rxShift   = rxPhitValid && (rxSof || rxPhase != '0);
    strobe.rxDeliver = rxPhitValid && !rxSof && (rxPhase == PH_W'(PHITS - 1));
    strobe.alignErr  = rxPhitValid && !rxSof && (rxPhase == '0);
    pktRemainNext    = pktRemain;
    if (strobe.rxDeliver) begin
      if (rxHeadBit) begin
        strobe.pktErr = (pktRemain != '0);
        strobe.pktEnd = !rxLenBit;
        pktRemainNext = rxLenBit ? REM_W'(LONG_FLITS - 1) : '0;
      end else if (pktRemain == '0) begin
        strobe.pktErr = 1'b1;
      end else begin
        strobe.pktEnd = (pktRemain == REM_W'(1));
        pktRemainNext = pktRemain - REM_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxPhase   <= '0;
      pktRemain <= '0;
    end else begin
      pktRemain <= pktRemainNext;
      if (rxPhitValid && rxSof)      rxPhase <= PH_W'(1);
      else if (strobe.rxDeliver)     rxPhase <= '0;
      else if (strobe.rxShift)       rxPhase <= rxPhase + PH_W'(1);
    end
  end

endmodule

// File: rtl/link_gearbox_dp.sv
module link_gearbox_dp
  import link_gearbox_pkg::*;
#(
  parameter int PHIT_W = 14,
  parameter int PHITS  = 5,
  localparam int FLIT_W = PHIT_W * PHITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gear_strobe_t      strobe,
  input  logic [FLIT_W-1:0] txFlit,
  output logic [PHIT_W-1:0] txPhit,
  input  logic [PHIT_W-1:0] rxPhit,
  output logic              rxFlitValid,
  output logic [FLIT_W-1:0] rxFlit,
  output logic              rxPktEnd,
  output logic              rxFrameErr,
  output logic              rxAlignErr
);

  logic [FLIT_W-1:0] txShreg;
  logic [FLIT_W-1:0] rxGather;
  logic [FLIT_W-1:0] rxGatherNext;

  assign txPhit       = txShreg[PHIT_W-1:0];
  // new phit enters at the top so the first phit ends in the lowest slice
  assign rxGatherNext = {rxPhit, rxGather[FLIT_W-1:PHIT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShreg     <= '0;
      rxGather    <= '0;
      rxFlit      <= '0;
      rxFlitValid <= 1'b0;
      rxPktEnd    <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxAlignErr  <= 1'b0;
    end else begin
      if (strobe.txLoad)       txShreg <= txFlit;
      else if (strobe.txShift) txShreg <= {PHIT_W'(0), txShreg[FLIT_W-1:PHIT_W]};
      if (strobe.rxShift)      rxGather <= rxGatherNext;
      if (strobe.rxDeliver)    rxFlit <= rxGatherNext;
      rxFlitValid <= strobe.rxDeliver;
      rxPktEnd    <= strobe.pktEnd;
      rxFrameErr  <= strobe.pktErr;
      rxAlignErr  <= strobe.alignErr;
    end
  end

endmodule

// File: rtl/link_phit_gearbox.sv
module link_phit_gearbox
  import link_gearbox_pkg::*;
#(
  parameter int PHIT_W     = 14,
  parameter int PHITS      = 5,
  parameter int DATA_W     = 64,
  parameter int CTRL_W     = 6,
  parameter int LONG_FLITS = 8,
  localparam int FLIT_W    = DATA_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txFlitValid,
  input  logic [FLIT_W-1:0] txFlit,
  output logic              txReady,
  output logic              txPhitValid,
  output logic [PHIT_W-1:0] txPhit,
  output logic              txSof,
  input  logic              rxPhitValid,
  input  logic [PHIT_W-1:0] rxPhit,
  input  logic              rxSof,
  output logic              rxFlitValid,
  output logic [FLIT_W-1:0] rxFlit,
  output logic              rxPktEnd,
  output logic              rxFrameErr,
  output logic              rxAlignErr
);

  // Control bits sit in the last phit; their position inside that phit.
  localparam int HEAD_POS = DATA_W - PHIT_W * (PHITS - 1);
  localparam int LEN_POS  = HEAD_POS + 1;

  gear_strobe_t strobe;

  link_gearbox_ctrl #(
    .PHITS      (PHITS),
    .LONG_FLITS (LONG_FLITS)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .txFlitValid (txFlitValid),
    .txReady     (txReady),
    .txPhitValid (txPhitValid),
    .txSof       (txSof),
    .rxPhitValid (rxPhitValid),
    .rxSof       (rxSof),
    .rxHeadBit   (rxPhit[HEAD_POS]),
    .rxLenBit    (rxPhit[LEN_POS]),
    .strobe      (strobe)
  );

  link_gearbox_dp #(
    .PHIT_W (PHIT_W),
    .PHITS  (PHITS)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .txFlit      (txFlit),
    .txPhit      (txPhit),
    .rxPhit      (rxPhit),
    .rxFlitValid (rxFlitValid),
    .rxFlit      (rxFlit),
    .rxPktEnd    (rxPktEnd),
    .rxFrameErr  (rxFrameErr),
    .rxAlignErr  (rxAlignErr)
  );

endmodule

// File: rtl/link_phit_gearbox_chk.sv
module link_phit_gearbox_chk (
  input logic clk,
  input logic rst_n,
  input logic txFlitValid,
  input logic txReady,
  input logic txPhitValid,
  input logic txSof,
  input logic rxPhitValid,
  input logic rxFlitValid,
  input logic rxPktEnd,
  input logic rxFrameErr,
  input logic rxAlignErr
);

  // R2: an accepted flit starts on the link at the next cycle
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (txFlitValid && txReady) |=> (txSof && txPhitValid));

  // R2: the phit after a start marker belongs to the same flit
  a_r2_sof_followed: assert property (@(posedge clk) disable iff (!rst_n)
    txSof |=> (txPhitValid && !txSof));

  // R3: no new flit while the first phit of a flit is on the wire
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    txSof |-> !txReady);

  // R5: a flit strobe follows a received phit
  a_r5_flit_after_phit: assert property (@(posedge clk) disable iff (!rst_n)
    rxFlitValid |-> $past(rxPhitValid));

  // R8: a dropped phit never coincides with a delivered flit
  a_r8_align_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rxAlignErr |-> !rxFlitValid);

  // R9 and R10: framing flags only accompany a flit
  a_r9_end_with_flit: assert property (@(posedge clk) disable iff (!rst_n)
    rxPktEnd |-> rxFlitValid);
  a_r10_err_with_flit: assert property (@(posedge clk) disable iff (!rst_n)
    rxFrameErr |-> rxFlitValid);

endmodule

bind link_phit_gearbox link_phit_gearbox_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txFlitValid (txFlitValid),
  .txReady     (txReady),
  .txPhitValid (txPhitValid),
  .txSof       (txSof),
  .rxPhitValid (rxPhitValid),
  .rxFlitValid (rxFlitValid),
  .rxPktEnd    (rxPktEnd),
  .rxFrameErr  (rxFrameErr),
  .rxAlignErr  (rxAlignErr)
);

// File: tb/test_link_phit_gearbox.sv
module test_link_phit_gearbox;

  localparam int PW = 14;
  localparam int NP = 5;
  localparam int FW = 70;

  typedef struct {
    logic [FW-1:0] flit;
    bit            pktEnd;
    bit            frameErr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txFlitValid = 1'b0;
  logic [FW-1:0] txFlit = '0;
  logic          txReady, txPhitValid, txSof;
  logic [PW-1:0] txPhit;
  logic          rxFlitValid, rxPktEnd, rxFrameErr, rxAlignErr;
  logic [FW-1:0] rxFlit;
  logic          loop = 1'b1;
  logic          drvValid = 1'b0;
  logic          drvSof = 1'b0;
  logic [PW-1:0] drvPhit = '0;
  logic          rxPhitValidIn, rxSofIn;
  logic [PW-1:0] rxPhitIn;

  assign rxPhitValidIn = loop ? txPhitValid : drvValid;
  assign rxSofIn       = loop ? txSof       : drvSof;
  assign rxPhitIn      = loop ? txPhit      : drvPhit;

  always #10 clk = ~clk;

  link_phit_gearbox i_link_phit_gearbox (
    .clk(clk), .rst_n(rst_n),
    .txFlitValid(txFlitValid), .txFlit(txFlit), .txReady(txReady),
    .txPhitValid(txPhitValid), .txPhit(txPhit), .txSof(txSof),
    .rxPhitValid(rxPhitValidIn), .rxPhit(rxPhitIn), .rxSof(rxSofIn),
    .rxFlitValid(rxFlitValid), .rxFlit(rxFlit), .rxPktEnd(rxPktEnd),
    .rxFrameErr(rxFrameErr), .rxAlignErr(rxAlignErr)
  );

  int   checks = 0;
  int   fails = 0;
  int   cycle = 0;
  int   lastSof = -1;
  bit   spacingOn = 1'b0;
  bit   alignOk = 1'b0;
  int   remain = 0;
  exp_t expQ[$];

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [63:0] d, input bit head, input bit len);
    return {4'b0, len, head, d};
  endfunction

  // Framing model from R9/R10
  task automatic pushExp(input logic [FW-1:0] f);
    exp_t e;
    e.flit = f; e.pktEnd = 0; e.frameErr = 0;
    if (f[64]) begin
      e.frameErr = (remain != 0);
      remain     = f[65] ? 7 : 0;
      e.pktEnd   = !f[65];
    end else if (remain == 0) begin
      e.frameErr = 1;
    end else begin
      remain--;
      e.pktEnd = (remain == 0);
    end
    expQ.push_back(e);
  endtask

  // Driver: offers a flit from a falling edge, returns at the falling edge after acceptance
  task automatic sendFlit(input logic [FW-1:0] f);
    txFlitValid = 1'b1;
    txFlit      = f;
    while (!txReady) @(negedge clk);
    pushExp(f);
    @(negedge clk);
    txFlitValid = 1'b0;
  endtask

  task automatic sendRxPhit(input logic [PW-1:0] p, input bit sof);
    drvValid = 1'b1; drvPhit = p; drvSof = sof;
    @(negedge clk);
    drvValid = 1'b0; drvSof = 1'b0;
  endtask

  // Monitor: scoreboard pop and spacing check
  always @(negedge clk) begin
    cycle++;
    if (rst_n) begin
      if (rxFlitValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected flit actual=%h expected=none", rxFlit);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk("R5 flit data", rxFlit, e.flit);
          chk("R9 packet end", FW'(rxPktEnd), FW'(e.pktEnd));
          chk("R10 frame error", FW'(rxFrameErr), FW'(e.frameErr));
        end
      end
      if (rxAlignErr && !alignOk) begin
        checks++; fails++;
        $display("FAIL R8 stray align error actual=1 expected=0");
      end
      if (txSof) begin
        if (spacingOn && lastSof >= 0) chk("R4 sof spacing", FW'(cycle - lastSof), FW'(NP));
        lastSof = cycle;
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [FW-1:0] f;
    logic [FW-1:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txReady", FW'(txReady), FW'(1));
    chk("R1 txPhitValid", FW'(txPhitValid), FW'(0));
    chk("R1 rxFlitValid", FW'(rxFlitValid), FW'(0));
    chk("R1 rx flags", FW'({rxPktEnd, rxFrameErr, rxAlignErr}), FW'(0));

    // R2 / R3: single flit, phit order and ready, ignored offer while busy
    f = mk(64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
    sendFlit(f);
    chk("R2 sof first", FW'(txSof), FW'(1));
    chk("R2 phit0", FW'(txPhit), FW'(f[13:0]));
    chk("R3 ready low", FW'(txReady), FW'(0));
    g = mk(64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0);
    txFlitValid = 1'b1; txFlit = g;
    @(negedge clk);
    txFlitValid = 1'b0;
    chk("R2 phit1", FW'(txPhit), FW'(f[27:14]));
    chk("R2 no sof", FW'(txSof), FW'(0));
    @(negedge clk);
    chk("R3 offer ignored phit2", FW'(txPhit), FW'(f[41:28]));
    @(negedge clk);
    chk("R2 phit3", FW'(txPhit), FW'(f[55:42]));
    @(negedge clk);
    chk("R2 phit4", FW'(txPhit), FW'(f[69:56]));
    chk("R3 ready on last", FW'(txReady), FW'(1));
    chk("R2 valid on last", FW'(txPhitValid), FW'(1));
    @(negedge clk);
    chk("R3 ignored flit not sent", FW'(txPhitValid), FW'(0));
    repeat (2) @(negedge clk);

    // R4 / R9: back-to-back long packet then a short one
    spacingOn = 1'b1; lastSof = -1;
    sendFlit(mk(64'hA000_0000_0000_0001, 1'b1, 1'b1));
    for (int i = 0; i < 7; i++) sendFlit(mk(64'hB000_0000_0000_0000 + 64'(i), 1'b0, 1'b0));
    sendFlit(mk(64'hC0DE_C0DE_C0DE_C0DE, 1'b1, 1'b0));
    repeat (6) @(negedge clk);
    spacingOn = 1'b0;

    // R10: head arrives while a long packet is open, then an orphan body flit
    sendFlit(mk(64'h1111, 1'b1, 1'b1));
    sendFlit(mk(64'h2222, 1'b0, 1'b0));
    sendFlit(mk(64'h3333, 1'b1, 1'b0));
    sendFlit(mk(64'h4444, 1'b0, 1'b0));
    repeat (8) @(negedge clk);

    // Receive-only cases
    loop = 1'b0;
    // R5 / R6: gaps between phits
    f = mk(64'h5555_AAAA_1234_8765, 1'b1, 1'b0);
    pushExp(f);
    sendRxPhit(f[13:0], 1'b1);
    @(negedge clk);
    sendRxPhit(f[27:14], 1'b0);
    repeat (3) @(negedge clk);
    sendRxPhit(f[41:28], 1'b0);
    sendRxPhit(f[55:42], 1'b0);
    @(negedge clk);
    chk("R6 no early flit", FW'(rxFlitValid), FW'(0));
    sendRxPhit(f[69:56], 1'b0);
    chk("R5 flit strobe after fifth phit", FW'(rxFlitValid), FW'(1));
    @(negedge clk);
    chk("R5 strobe one cycle", FW'(rxFlitValid), FW'(0));

    // R8: stray phit with no flit in progress
    alignOk = 1'b1;
    sendRxPhit(14'h2AAA, 1'b0);
    chk("R8 align error", FW'(rxAlignErr), FW'(1));
    chk("R8 no flit", FW'(rxFlitValid), FW'(0));
    @(negedge clk);
    chk("R8 align pulse", FW'(rxAlignErr), FW'(0));
    alignOk = 1'b0;

    // R7: restart mid flit
    g = mk(64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0);
    sendRxPhit(14'h0111, 1'b1);
    sendRxPhit(14'h0222, 1'b0);
    sendRxPhit(14'h0333, 1'b0);
    pushExp(g);
    sendRxPhit(g[13:0], 1'b1);
    sendRxPhit(g[27:14], 1'b0);
    sendRxPhit(g[41:28], 1'b0);
    sendRxPhit(g[55:42], 1'b0);
    chk("R7 no flit from partial", FW'(rxFlitValid), FW'(0));
    sendRxPhit(g[69:56], 1'b0);
    chk("R7 realigned flit", rxFlit, g);
    repeat (4) @(negedge clk);

    chk("R5 scoreboard drained", FW'(expQ.size()), FW'(0));
    finishRun();
  end

endmodule